// File: doc/BRIEF.md
# Padded Streaming 3x3 Window Generator

This block turns a raster-ordered pixel stream into a stream of complete 3x3 neighbourhoods, one per accepted pixel, for a stride-1 convolution engine placed after it. Every stream word carries all depth channels of one pixel packed side by side, so each of the nine window taps is a full depth vector. A downstream datapath can split the taps per channel and work on all of them at once.

Two line buffers hold the previous two image rows, and a small register array holds the two previous columns. The border of the image is padded with zeros inside the pipeline, one pixel wide on every side. As a result a frame of IMG_W x IMG_H pixels yields exactly IMG_W x IMG_H windows, centred on each pixel in raster order. Two register positions that would join the end of one row to the start of the next are not used for such a mixed window. Instead, at those steps the block emits the right-border and left-border windows, with the foreign column forced to zero.

The output runs a fixed IMG_W+1 steps behind the input. After the last pixel of a frame, the block runs IMG_W+1 extra cycles on its own to emit the bottom-row windows.

Top module: `padded_window_gen`

## Requirements
- R1: A synchronous active-high reset drives out_valid, out_last and out_window to zero and returns the frame position to the first pixel. A frame that starts after a reset issued mid-frame is processed correctly.
- R2: A pixel word holds CHANNELS channels of CH_BITS bits each, with channel i at bits [i*CH_BITS +: CH_BITS]. out_window holds nine words, and tap t = 3*row + col sits at bits [t*WORD +: WORD]. Row 0 is the upper image row and col 0 is the left image column.
- R3: For a centre pixel (r,c), the tap at (row,col) equals the input pixel (r+row-1, c+col-1) whenever that position lies inside the image.
- R4: A tap whose position lies outside the image is all zeros, whatever the line buffers hold. This applies to the top, bottom, left and right borders and to the corners.
- R5: Each frame produces exactly IMG_W*IMG_H windows with centres in raster order. out_last is high together with out_valid on the final window only.
- R6: The window centred on linear pixel index k is emitted on the clock edge that accepts pixel k+IMG_W+1. The last IMG_W+1 windows come on consecutive self-timed cycles right after the last pixel, with no input needed.
- R7: No window is flagged valid while the first IMG_W+1 pixels of a frame are accepted. No window ever mixes pixels from the two ends of a row.
- R8: in_valid is ignored during the self-timed tail after the last pixel. A pixel presented there changes neither the tail windows nor the next frame.
- R9: A cycle without in_valid inside a frame produces no window and leaves later window contents unchanged. With continuous input, one window leaves per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel word present on in_data |
| in_data | input | CHANNELS*CH_BITS | Depth-packed pixel word |
| out_valid | output | 1 | out_window carries a window this cycle |
| out_window | output | 9*CHANNELS*CH_BITS | Nine packed taps, tap 3*row+col at word index |
| out_last | output | 1 | Final window of the frame |

## Verification
Every result is registered: the window for centre k appears after the edge that accepts pixel k+IMG_W+1, or after the matching tail cycle, and out_last appears with the final tail step. The bench drives inputs just after the falling edge and samples outputs at the next falling edge. It counts the steps it has issued, so for each sampled cycle it knows whether a window is due and which centre it belongs to. The contents are compared against neighbourhoods computed from the same pixel formula, with zeros outside the image. Gapped input patterns, a stray pixel in the tail, back-to-back frames and a mid-frame reset exercise the timing corners.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

  localparam int KDIM  = 3;
  localparam int KTAPS = KDIM * KDIM;

  typedef struct packed {
    logic top;
    logic bottom;
    logic left;
    logic right;
  } pad_mask_t;

  // A tap is blanked when it falls on a padded border of the centre pixel.
  function automatic logic tap_blank(pad_mask_t m, int row, int col);
    return (row == 0 && m.top) || (row == KDIM - 1 && m.bottom) ||
           (col == 0 && m.left) || (col == KDIM - 1 && m.right);
  endfunction

endpackage

// File: rtl/pwg_line_buffer.sv
module pwg_line_buffer #(
  parameter int DEPTH = 5,
  parameter int WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  // Read one slot ahead so the registered output already holds the word
  // written DEPTH shifts before the next shift.
  always_comb begin
    if (wr_ptr == LAST_ADDR) rd_ptr = '0;
    else                     rd_ptr = wr_ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (shift) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      dout   <= '0;
    end else if (shift) begin
      wr_ptr <= rd_ptr;
      dout   <= mem[rd_ptr];
    end
  end

endmodule

// File: rtl/pwg_scan_ctrl.sv
module pwg_scan_ctrl
  import pwg_pkg::*;
#(
  parameter int IMG_W = 5,
  parameter int IMG_H = 5
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      in_valid,
  output logic      step,
  output logic      in_phase,
  output logic      emit,
  output logic      frame_end,
  output pad_mask_t pad
);

  localparam int RW = $clog2(IMG_H + 2);
  localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam logic [RW-1:0] ROW_IMG   = RW'(IMG_H);
  localparam logic [RW-1:0] ROW_END   = RW'(IMG_H + 1);
  localparam logic [RW-1:0] ROW_BOT   = RW'(IMG_H - 1);
  localparam logic [CW-1:0] COL_LAST  = CW'(IMG_W - 1);

  // Step position in raster order; rows IMG_H and IMG_H+1 form the tail.
  logic [RW-1:0] srow;
  logic [CW-1:0] scol;
  logic [RW-1:0] crow;
  logic [CW-1:0] ccol;

  always_comb begin
    in_phase  = (srow < ROW_IMG);
    step      = in_phase ? in_valid : 1'b1;
    emit      = (srow >= RW'(2)) || ((srow == RW'(1)) && (scol != '0));
    frame_end = (srow == ROW_END);
    // Centre of the emitted window trails the step by IMG_W+1 positions.
    if (scol == '0) begin
      crow = srow - RW'(2);
      ccol = COL_LAST;
    end else begin
      crow = srow - RW'(1);
      ccol = scol - CW'(1);
    end
    pad.top    = (crow == '0);
    pad.bottom = (crow == ROW_BOT);
    pad.left   = (ccol == '0);
    pad.right  = (ccol == COL_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srow <= '0;
      scol <= '0;
    end else if (step) begin
      if (frame_end) begin
        srow <= '0;
        scol <= '0;
      end else if (scol == COL_LAST) begin
        scol <= '0;
        srow <= srow + RW'(1);
      end else begin
        scol <= scol + CW'(1);
      end
    end
  end

endmodule

// File: rtl/pwg_window_regs.sv
module pwg_window_regs
  import pwg_pkg::*;
#(
  parameter int WORD = 96
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step,
  input  logic                       emit,
  input  logic                       frame_end,
  input  pad_mask_t                  pad,
  input  logic [KDIM-1:0][WORD-1:0]  new_col,
  output logic                       out_valid,
  output logic                       out_last,
  output logic [KTAPS*WORD-1:0]      out_window
);

  // hist[row][0] is the older column, hist[row][1] the newer one.
  logic [KDIM-1:0][KDIM-2:0][WORD-1:0] hist;
  logic [KTAPS-1:0][WORD-1:0]          raw_taps;
  logic [KTAPS-1:0][WORD-1:0]          masked_taps;
  logic [KTAPS-1:0][WORD-1:0]          win_q;

  for (genvar r = 0; r < KDIM; r++) begin : g_row
    for (genvar c = 0; c < KDIM; c++) begin : g_col
      localparam int T = r * KDIM + c;
      if (c == KDIM - 1) begin : g_fresh
        assign raw_taps[T] = new_col[r];
      end else begin : g_held
        assign raw_taps[T] = hist[r][c];
      end
      assign masked_taps[T] = tap_blank(pad, r, c) ? '0 : raw_taps[T];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist      <= '0;
      win_q     <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= step && emit;
      out_last  <= step && frame_end;
      if (step) begin
        for (int r = 0; r < KDIM; r++) begin
          hist[r][0] <= hist[r][1];
          hist[r][1] <= new_col[r];
        end
      end
      if (step && emit) win_q <= masked_taps;
    end
  end

  assign out_window = win_q;

endmodule

// File: rtl/padded_window_gen.sv
module padded_window_gen
  import pwg_pkg::*;
#(
  parameter int IMG_W    = 5,
  parameter int IMG_H    = 5,
  parameter int CHANNELS = 3,
  parameter int CH_BITS  = 32,
  localparam int WORD     = CHANNELS * CH_BITS,
  localparam int WIN_BITS = KTAPS * WORD
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [WORD-1:0]     in_data,
  output logic                out_valid,
  output logic [WIN_BITS-1:0] out_window,
  output logic                out_last
);

  logic      step;
  logic      in_phase;
  logic      emit;
  logic      frame_end;
  pad_mask_t pad;

  logic [WORD-1:0] pix;
  logic [WORD-1:0] row_prev;
  logic [WORD-1:0] row_prev2;
  logic [KDIM-1:0][WORD-1:0] new_col;

  pwg_scan_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .step      (step),
    .in_phase  (in_phase),
    .emit      (emit),
    .frame_end (frame_end),
    .pad       (pad)
  );

  // Tail steps feed zeros; those taps are blanked as bottom padding anyway.
  assign pix = in_phase ? in_data : '0;

  pwg_line_buffer #(.DEPTH(IMG_W), .WIDTH(WORD)) u_lb_near (
    .clk   (clk),
    .rst   (rst),
    .shift (step),
    .din   (pix),
    .dout  (row_prev)
  );

  pwg_line_buffer #(.DEPTH(IMG_W), .WIDTH(WORD)) u_lb_far (
    .clk   (clk),
    .rst   (rst),
    .shift (step),
    .din   (row_prev),
    .dout  (row_prev2)
  );

  assign new_col[0] = row_prev2;
  assign new_col[1] = row_prev;
  assign new_col[2] = pix;

  pwg_window_regs #(.WORD(WORD)) u_win (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .emit       (emit),
    .frame_end  (frame_end),
    .pad        (pad),
    .new_col    (new_col),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .out_window (out_window)
  );

endmodule

// File: rtl/pwg_checker.sv
module pwg_checker #(
  parameter int WORD = 96
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_phase,
  input logic              out_valid,
  input logic              out_last,
  input logic [9*WORD-1:0] out_window
);

  // R5: the frame marker only rides on a valid window
  a_r5_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R1: reset silences the output on the following cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_last));

  // R9: an idle input cycle inside the frame yields no window
  a_r9_idle_no_window: assert property (@(posedge clk) disable iff (rst)
    (in_phase && !in_valid) |=> !out_valid);

  // R6: every tail cycle emits a window
  a_r6_tail_streams: assert property (@(posedge clk) disable iff (rst)
    !in_phase |=> out_valid);

  // R4: the final window has blank bottom row and right column
  a_r4_last_corner_zero: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_window[2*WORD +: WORD] == '0 &&
                  out_window[5*WORD +: WORD] == '0 &&
                  out_window[6*WORD +: WORD] == '0 &&
                  out_window[7*WORD +: WORD] == '0 &&
                  out_window[8*WORD +: WORD] == '0));

endmodule

bind padded_window_gen pwg_checker #(.WORD(WORD)) u_pwg_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_phase   (in_phase),
  .out_valid  (out_valid),
  .out_last   (out_last),
  .out_window (out_window)
);

// File: tb/padded_window_gen_test.sv
`timescale 1ns/1ps
module padded_window_gen_test;

  localparam int W = 5;
  localparam int H = 5;
  localparam int CH = 3;
  localparam int CB = 32;
  localparam int WD = CH * CB;
  localparam int WB = 9 * WD;
  localparam int NPIX = W * H;

  // Case table: {seed[7:0], gap mode[3:0], stray-in-tail[3:0]}
  // gap mode 0 continuous, 1 idle every third cycle, 2 alternate idle
  localparam logic [15:0] CASES [5] = '{16'h01_00, 16'h02_10, 16'h03_20,
                                        16'h04_01, 16'h05_00};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [WD-1:0] in_data = '0;
  logic out_valid;
  logic [WB-1:0] out_window;
  logic out_last;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  padded_window_gen #(.IMG_W(W), .IMG_H(H), .CHANNELS(CH), .CH_BITS(CB)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_window(out_window), .out_last(out_last));

  function automatic logic [WD-1:0] pixel(int seed, int r, int c);
    logic [WD-1:0] w;
    for (int ch = 0; ch < CH; ch++)
      w[ch*CB +: CB] = 32'(seed * 4096 + r * 256 + c * 16 + ch + 1);
    return w;
  endfunction

  function automatic logic [WB-1:0] expect_win(int seed, int k);
    logic [WB-1:0] e;
    int cr, cc, y, x;
    cr = k / W;
    cc = k % W;
    e = '0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin
        y = cr + r - 1;
        x = cc + c - 1;
        if (y >= 0 && y < H && x >= 0 && x < W)
          e[(r*3+c)*WD +: WD] = pixel(seed, y, x);
      end
    return e;
  endfunction

  task automatic check(bit ok, string req, logic [WB-1:0] act, logic [WB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one frame starting at a falling edge; checks every sampled cycle.
  task automatic run_frame(int seed, int mode, bit stray);
    int p = 0, s = 0, cyc = 0, k = 0, tail_cyc = 0;
    bit stepped, ev, el, border;
    logic [WB-1:0] ew;
    while (s <= NPIX + W && cyc < 4000) begin
      stepped = 1'b0;
      if (p < NPIX) begin
        in_valid = !((mode == 1 && cyc % 3 == 2) || (mode == 2 && cyc % 2 == 1));
        in_data  = pixel(seed, p / W, p % W);
        if (in_valid) begin p++; stepped = 1'b1; end
      end else begin
        in_valid = stray && (tail_cyc == 2);
        in_data  = {CH{32'hDEAD_BEEF}};
        tail_cyc++;
        stepped = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      ev = stepped && (s >= W + 1);
      el = stepped && (s == NPIX + W);
      // R7 (fill) / R9 (idle) / R6 (timing): valid due exactly on these steps
      check(out_valid == ev, (stepped && s < W + 1) ? "R7 fill no window" :
            (stepped ? "R6 window timing" : "R9 idle no window"),
            WB'(out_valid), WB'(ev));
      check(out_last == el, "R5 out_last placement", WB'(out_last), WB'(el));
      if (out_valid && ev) begin
        ew = expect_win(seed, k);
        border = (k / W == 0) || (k / W == H - 1) || (k % W == 0) || (k % W == W - 1);
        check(out_window == ew, border ? (stray ? "R8 R4 border window" : "R4 border window")
              : "R3 R2 interior window", out_window, ew);
        k++;
      end
      if (stepped) s++;
      cyc++;
    end
    in_valid = 1'b0;
    check(k == NPIX, "R5 window count", WB'(k), WB'(NPIX));
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0 && out_last == 1'b0, "R1 reset flags",
          WB'({out_valid, out_last}), '0);
    check(out_window == '0, "R1 reset window", out_window, '0);
    rst = 1'b0;

    for (int i = 0; i < 5; i++)
      run_frame(int'(CASES[i][15:8]), int'(CASES[i][7:4]), CASES[i][0]);

    // R1: reset in mid-frame, then a clean frame
    for (int i = 0; i < 12; i++) begin
      in_valid = 1'b1;
      in_data  = pixel(9, i / W, i % W);
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 mid-frame reset", WB'(out_valid), '0);
    rst = 1'b0;
    run_frame(7, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule